// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers a parameterized set of maskable interrupt requests plus a handful of fixed special events. It selects one winner for the main CPU and, separately, one for a coprocessor. Each maskable request carries a programmable level (0 to 7) and a route bit that sends it either to the CPU or to the coprocessor. The CPU side honours the CPU's current processing level and the I mask, so higher-level requests can nest over a running handler. The coprocessor side receives its winning vector on a registered output every cycle.

Every vector is a 16-bit address. The upper byte comes from a programmable base register. The lower byte is a fixed offset inside the 256-byte page that the base selects. When the CPU acknowledges, the block captures the current CPU winner into a vector register. It holds that value until the CPU signals that the fetch is complete. If nothing qualifies when the acknowledge arrives, the captured value is the spurious vector.

Two wake outputs let the CPU and the coprocessor leave stop or wait modes independently. An XIRQ assertion raises the CPU wake even while the X mask is set.

Top module: `prio_vec_ctrl`

## Requirements
- R1: After a synchronous active-low reset, cpu_irq_req, cpu_vec_valid, cop_valid, wake_cpu and wake_cop are 0, all levels are 0, all routes point to the CPU, and the base register holds BASE_RST (default 0xFF).
- R2: Maskable request i has the vector {base, 0xF2 - 2*i}. The special vectors are {base, 0xF8} for trap, 0xF6 for software interrupt, 0xF4 for XIRQ, 0x18/0x16/0x14 for access violations 2/1/0, and 0x12 for the system call.
- R3: A maskable request whose level is 0 is disabled: it never wins on either side and never raises a wake.
- R4: A CPU-routed maskable request competes for the CPU only when i_mask is 0 and its level is strictly greater than cpu_ipl.
- R5: Among competing maskable requests, the higher level wins. At equal level, the lower index (the higher vector address) wins.
- R6: A request whose route bit is 1 is arbitrated for the coprocessor only. One cycle later cop_valid is 1, and cop_vec and cop_lvl give its vector and level. This is independent of i_mask and cpu_ipl, and the request is invisible to the CPU side.
- R7: Request index 0 (the IRQ pin request) is CPU-only: a route write of 1 to index 0 is ignored.
- R8: The CPU selection order is fixed: trap, software interrupt, XIRQ (only when x_mask is 0), the maskable winner, access violation 2, 1, 0, then system call. cpu_irq_req goes to 1 one cycle after any of these is pending.
- R9: An acknowledge with no qualifying CPU candidate captures the spurious vector {base, 0x10} with cpu_take_lvl 0.
- R10: On cpu_ack while cpu_vec_valid is 0, the next edge loads cpu_vec (and cpu_take_lvl: the winner's level for a maskable vector, else 0) and sets cpu_vec_valid. Both values stay unchanged, and further acknowledges are ignored, until a cycle with cpu_fetch_done clears cpu_vec_valid.
- R11: One cycle later, wake_cpu is 1 if any of the following holds: xirq is high (whatever x_mask is), a trap/software/access/system-call event is pending, or a CPU-routed request with nonzero level is pending while i_mask is 0. cpu_ipl plays no part in this.
- R12: wake_cop is 1 one cycle after any coprocessor-routed request with nonzero level is pending, whatever the CPU-side masks.
- R13: A base write changes the upper byte of every later vector. A configuration write with cfg_idx at or above N_REQ has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_we | input | 1 | Write strobe for the vector base byte |
| base_wdata | input | 8 | New vector base byte |
| cfg_we | input | 1 | Write strobe for one request's configuration |
| cfg_idx | input | IDX_W | Request index being configured |
| cfg_lvl | input | 3 | Level to store (0 disables) |
| cfg_cop | input | 1 | Route to store: 1 coprocessor, 0 CPU |
| irq_req | input | N_REQ | Maskable request lines, level sensitive |
| xirq | input | 1 | XIRQ request |
| x_mask | input | 1 | X mask from the CPU |
| i_mask | input | 1 | I mask from the CPU |
| cpu_ipl | input | 3 | CPU's current processing level |
| trap_req | input | 1 | Unimplemented-opcode trap event |
| swi_req | input | 1 | Software interrupt / debug event |
| acc_viol | input | 3 | Access violation events |
| sys_call | input | 1 | System call event |
| cpu_ack | input | 1 | CPU vector acknowledge |
| cpu_fetch_done | input | 1 | CPU finished fetching the vector |
| cpu_irq_req | output | 1 | A CPU candidate is pending |
| cpu_vec | output | 16 | Captured CPU vector address |
| cpu_vec_valid | output | 1 | cpu_vec is held for the CPU |
| cpu_take_lvl | output | 3 | Level of the captured maskable vector, else 0 |
| cop_valid | output | 1 | A coprocessor request is presented |
| cop_vec | output | 16 | Coprocessor vector address |
| cop_lvl | output | 3 | Level of the coprocessor winner |
| wake_cpu | output | 1 | Wake request for the CPU |
| wake_cop | output | 1 | Wake request for the coprocessor |

## Verification
Some properties are checked on every cycle: the held CPU vector stays constant until the fetch completes, a captured maskable level always exceeds the processing level seen at capture, each arbiter's winner is eligible and is beaten by no other eligible request in level or tie order, index 0 never reaches the coprocessor, and XIRQ always wakes the CPU. The exact vector addresses, the fixed order of the special events, level-zero disabling, ignored route writes, base changes and the spurious case are shown only by the bench. The bench sweeps every index, level and processing level, every request pair at several levels, and every combination of special events.

// File: rtl/ivc_pkg.sv
// Package: shared types and vector-page offsets for the interrupt vector controller.
// Assumes a 3-bit level field and at most 109 maskable requests per page.
package ivc_pkg;
    localparam int LVL_W   = 3;
    localparam int MAX_REQ = 109;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam logic [7:0] OFS_SPUR  = 8'h10;
    localparam logic [7:0] OFS_SYS   = 8'h12;
    localparam logic [7:0] OFS_ACC0  = 8'h14;
    localparam logic [7:0] OFS_TOP_I = 8'hF2;
    localparam logic [7:0] OFS_XIRQ  = 8'hF4;
    localparam logic [7:0] OFS_SWI   = 8'hF6;
    localparam logic [7:0] OFS_TRAP  = 8'hF8;
endpackage

// File: rtl/ivc_cfg_regs.sv
// Module: configuration storage (vector base byte, per-request level and route).
// Assumes one write per cycle; an index outside the request range is dropped.
// Index 0 is the CPU-only request, so its route bit is fixed to the CPU.
module ivc_cfg_regs
    import ivc_pkg::*;
#(
    parameter int         N_REQ    = 16,
    parameter int         IDX_W    = 4,
    parameter logic [7:0] BASE_RST = 8'hFF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   base_we,
    input  logic [7:0]             base_wdata,
    input  logic                   cfg_we,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  lvl_t                   cfg_lvl,
    input  logic                   cfg_cop,
    output logic [7:0]             base_q,
    output lvl_t [N_REQ-1:0]       lvl_q,
    output logic [N_REQ-1:0]       cop_q
);

    // Vector base byte register.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= BASE_RST;
        else if (base_we) base_q <= base_wdata;
    end

    for (genvar g = 0; g < N_REQ; g++) begin : g_slot
        // Level register of request g.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   lvl_q[g] <= '0;
            else if (cfg_we && (int'(cfg_idx) == g))      lvl_q[g] <= cfg_lvl;
        end

        if (g == 0) begin : g_cpu_only
            assign cop_q[g] = 1'b0;
        end else begin : g_routable
            // Route register of request g.
            always_ff @(posedge clk) begin
                if (!rst_n)                               cop_q[g] <= 1'b0;
                else if (cfg_we && (int'(cfg_idx) == g))  cop_q[g] <= cfg_cop;
            end
        end
    end

endmodule

// File: rtl/ivc_arbiter.sv
// Module: level arbiter. Picks the eligible request with the highest level;
// on a tie the lowest index (highest vector address) wins.
// Assumes eligibility already folds in masking and routing.
module ivc_arbiter
    import ivc_pkg::*;
#(
    parameter int N_REQ = 16,
    parameter int IDX_W = 4
) (
    input  logic [N_REQ-1:0]  elig,
    input  lvl_t [N_REQ-1:0]  lvl,
    output logic              found,
    output logic [IDX_W-1:0]  win_idx,
    output lvl_t              win_lvl
);

    // Descending scan: >= lets a lower index take over at equal level.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (elig[i] && (!found || lvl[i] >= win_lvl)) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = lvl[i];
            end
        end
    end

    logic order_ok;
    // Checker helper: no eligible request outranks the reported winner.
    always_comb begin
        order_ok = 1'b1;
        if (found) begin
            for (int j = 0; j < N_REQ; j++) begin
                if (elig[j] && (lvl[j] > win_lvl ||
                    (lvl[j] == win_lvl && j < int'(win_idx))))
                    order_ok = 1'b0;
            end
        end
    end

    // R5
    always_comb begin
        if (found) win_elig_chk: assert (elig[win_idx]);
    end

    // R5
    always_comb begin
        win_order_chk: assert (order_ok);
    end

endmodule

// File: rtl/ivc_cpu_port.sv
// Module: CPU-side vector selection, request flag and acknowledge capture.
// Assumes special events are held by their sources until serviced.
// The captured vector is frozen from acknowledge until fetch completion.
module ivc_cpu_port
    import ivc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        base,
    input  logic              i_found,
    input  logic [IDX_W-1:0]  i_idx,
    input  lvl_t              i_lvl,
    input  logic              trap_req,
    input  logic              swi_req,
    input  logic              xirq,
    input  logic              x_mask,
    input  logic              i_mask,
    input  lvl_t              cpu_ipl,
    input  logic [2:0]        acc_viol,
    input  logic              sys_call,
    input  logic              cpu_ack,
    input  logic              cpu_fetch_done,
    output logic              cpu_irq_req,
    output logic [15:0]       cpu_vec,
    output logic              cpu_vec_valid,
    output lvl_t              cpu_take_lvl
);

    logic       sel_any;
    logic [7:0] sel_ofs;
    lvl_t       sel_lvl;
    logic [7:0] i_ofs;

    assign i_ofs = OFS_TOP_I - 8'({i_idx, 1'b0});

    // Fixed-order selection among special events and the maskable winner.
    always_comb begin
        sel_any = 1'b1;
        sel_lvl = '0;
        sel_ofs = OFS_SPUR;
        if (trap_req)               sel_ofs = OFS_TRAP;
        else if (swi_req)           sel_ofs = OFS_SWI;
        else if (xirq && !x_mask)   sel_ofs = OFS_XIRQ;
        else if (i_found) begin
            sel_ofs = i_ofs;
            sel_lvl = i_lvl;
        end
        else if (acc_viol[2])       sel_ofs = OFS_ACC0 + 8'd4;
        else if (acc_viol[1])       sel_ofs = OFS_ACC0 + 8'd2;
        else if (acc_viol[0])       sel_ofs = OFS_ACC0;
        else if (sys_call)          sel_ofs = OFS_SYS;
        else                        sel_any = 1'b0;
    end

    // Registered pending flag toward the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_irq_req <= 1'b0;
        else        cpu_irq_req <= sel_any;
    end

    // Acknowledge capture and hold until the fetch completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_vec       <= '0;
            cpu_take_lvl  <= '0;
            cpu_vec_valid <= 1'b0;
        end else if (cpu_vec_valid) begin
            if (cpu_fetch_done) cpu_vec_valid <= 1'b0;
        end else if (cpu_ack) begin
            cpu_vec       <= {base, sel_ofs};
            cpu_take_lvl  <= sel_lvl;
            cpu_vec_valid <= 1'b1;
        end
    end

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_vec_valid && !cpu_fetch_done) |=> ($stable(cpu_vec) && $stable(cpu_take_lvl) && cpu_vec_valid));

    // R4
    nest_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_vec_valid) && cpu_take_lvl != '0) |-> (cpu_take_lvl > $past(cpu_ipl) && !$past(i_mask)));

    // R9
    spur_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_vec_valid) && cpu_vec[7:0] == OFS_SPUR) |-> (cpu_take_lvl == '0));

endmodule

// File: rtl/prio_vec_ctrl.sv
// Module: top of the interrupt vector controller. Forms per-target eligibility,
// runs one arbiter per target, drives the CPU port, the coprocessor vector and
// the two wake outputs. All outputs are registered.
module prio_vec_ctrl
    import ivc_pkg::*;
#(
    parameter int         N_REQ    = 16,
    parameter logic [7:0] BASE_RST = 8'hFF,
    localparam int        IDX_W    = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [7:0]        base_wdata,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [2:0]        cfg_lvl,
    input  logic              cfg_cop,
    input  logic [N_REQ-1:0]  irq_req,
    input  logic              xirq,
    input  logic              x_mask,
    input  logic              i_mask,
    input  logic [2:0]        cpu_ipl,
    input  logic              trap_req,
    input  logic              swi_req,
    input  logic [2:0]        acc_viol,
    input  logic              sys_call,
    input  logic              cpu_ack,
    input  logic              cpu_fetch_done,
    output logic              cpu_irq_req,
    output logic [15:0]       cpu_vec,
    output logic              cpu_vec_valid,
    output logic [2:0]        cpu_take_lvl,
    output logic              cop_valid,
    output logic [15:0]       cop_vec,
    output logic [2:0]        cop_lvl,
    output logic              wake_cpu,
    output logic              wake_cop
);

    logic [7:0]        base_q;
    lvl_t [N_REQ-1:0]  lvl_q;
    logic [N_REQ-1:0]  cop_q;
    logic [N_REQ-1:0]  elig_cpu, elig_cop, pend_cpu;

    ivc_cfg_regs #(.N_REQ(N_REQ), .IDX_W(IDX_W), .BASE_RST(BASE_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .base_we(base_we), .base_wdata(base_wdata),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl), .cfg_cop(cfg_cop),
        .base_q(base_q), .lvl_q(lvl_q), .cop_q(cop_q)
    );

    for (genvar g = 0; g < N_REQ; g++) begin : g_elig
        assign pend_cpu[g] = irq_req[g] && !cop_q[g] && (lvl_q[g] != '0);
        assign elig_cpu[g] = pend_cpu[g] && !i_mask && (lvl_q[g] > cpu_ipl);
        assign elig_cop[g] = irq_req[g] && cop_q[g] && (lvl_q[g] != '0);
    end

    logic              cpu_found, cop_found;
    logic [IDX_W-1:0]  cpu_idx, cop_idx;
    lvl_t              cpu_wlvl, cop_wlvl;

    ivc_arbiter #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_arb_cpu (
        .elig(elig_cpu), .lvl(lvl_q),
        .found(cpu_found), .win_idx(cpu_idx), .win_lvl(cpu_wlvl)
    );

    ivc_arbiter #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_arb_cop (
        .elig(elig_cop), .lvl(lvl_q),
        .found(cop_found), .win_idx(cop_idx), .win_lvl(cop_wlvl)
    );

    ivc_cpu_port #(.IDX_W(IDX_W)) u_cpu (
        .clk(clk), .rst_n(rst_n), .base(base_q),
        .i_found(cpu_found), .i_idx(cpu_idx), .i_lvl(cpu_wlvl),
        .trap_req(trap_req), .swi_req(swi_req), .xirq(xirq), .x_mask(x_mask),
        .i_mask(i_mask), .cpu_ipl(cpu_ipl), .acc_viol(acc_viol), .sys_call(sys_call),
        .cpu_ack(cpu_ack), .cpu_fetch_done(cpu_fetch_done),
        .cpu_irq_req(cpu_irq_req), .cpu_vec(cpu_vec),
        .cpu_vec_valid(cpu_vec_valid), .cpu_take_lvl(cpu_take_lvl)
    );

    // Registered coprocessor vector, refreshed every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cop_valid <= 1'b0;
            cop_vec   <= '0;
            cop_lvl   <= '0;
        end else begin
            cop_valid <= cop_found;
            cop_vec   <= {base_q, OFS_TOP_I - 8'({cop_idx, 1'b0})};
            cop_lvl   <= cop_wlvl;
        end
    end

    // Registered wake requests for both targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_cpu <= 1'b0;
            wake_cop <= 1'b0;
        end else begin
            wake_cpu <= xirq || trap_req || swi_req || (|acc_viol) || sys_call ||
                        (!i_mask && (|pend_cpu));
            wake_cop <= |elig_cop;
        end
    end

    // R7
    irq_not_cop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cop_valid |-> (cop_vec[7:0] != OFS_TOP_I));

    // R11
    xirq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xirq |=> wake_cpu);

    // R6
    cop_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cop_valid |-> (cop_lvl != '0 && wake_cop));

endmodule

// File: tb/prio_vec_ctrl_bench.sv
`timescale 1ns/1ps
module prio_vec_ctrl_bench;
    localparam int N  = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic base_we = 0, cfg_we = 0, cfg_cop = 0;
    logic [7:0] base_wdata = 0;
    logic [IW-1:0] cfg_idx = 0;
    logic [2:0] cfg_lvl = 0, cpu_ipl = 0;
    logic [N-1:0] irq_req = 0;
    logic xirq = 0, x_mask = 0, i_mask = 0, trap_req = 0, swi_req = 0, sys_call = 0;
    logic [2:0] acc_viol = 0;
    logic cpu_ack = 0, cpu_fetch_done = 0;
    logic cpu_irq_req, cpu_vec_valid, cop_valid, wake_cpu, wake_cop;
    logic [15:0] cpu_vec, cop_vec;
    logic [2:0] cpu_take_lvl, cop_lvl;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] base = 8'hFF;
    logic [15:0] got_vec;
    logic [2:0] got_lvl;

    always #4 clk = ~clk;

    prio_vec_ctrl #(.N_REQ(N)) u_prio_vec_ctrl (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl), .cfg_cop(cfg_cop),
        .irq_req(irq_req), .xirq(xirq), .x_mask(x_mask), .i_mask(i_mask),
        .cpu_ipl(cpu_ipl), .trap_req(trap_req), .swi_req(swi_req),
        .acc_viol(acc_viol), .sys_call(sys_call), .cpu_ack(cpu_ack),
        .cpu_fetch_done(cpu_fetch_done), .cpu_irq_req(cpu_irq_req),
        .cpu_vec(cpu_vec), .cpu_vec_valid(cpu_vec_valid), .cpu_take_lvl(cpu_take_lvl),
        .cop_valid(cop_valid), .cop_vec(cop_vec), .cop_lvl(cop_lvl),
        .wake_cpu(wake_cpu), .wake_cop(wake_cop)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wcfg(int idx, int lvl, bit cop);
        @(negedge clk);
        cfg_we = 1; cfg_idx = IW'(idx); cfg_lvl = 3'(lvl); cfg_cop = cop;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic do_ack();
        @(negedge clk); cpu_ack = 1;
        @(negedge clk); cpu_ack = 0;
        got_vec = cpu_vec; got_lvl = cpu_take_lvl;
        cpu_fetch_done = 1;
        @(negedge clk); cpu_fetch_done = 0;
    endtask

    function automatic logic [15:0] ivec(int i);
        return {base, 8'(8'hF2 - 2 * i)};
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq_req", cpu_irq_req, 0);
        check("R1 vec_valid", cpu_vec_valid, 0);
        check("R1 cop_valid", cop_valid, 0);
        check("R1 wake_cpu", wake_cpu, 0);
        check("R1 wake_cop", wake_cop, 0);
        // R9 spurious with reset base
        do_ack();
        check("R9 R1 spurious vec", got_vec, 16'hFF10);
        check("R9 spurious lvl", got_lvl, 0);

        // R2 R3 R4 sweep over index, level, processing level
        for (int i = 0; i < N; i++) begin
            for (int l = 0; l < 8; l++) begin
                wcfg(i, l, 0);
                irq_req = '0; irq_req[i] = 1'b1;
                for (int p = 0; p < 8; p++) begin
                    cpu_ipl = 3'(p);
                    settle();
                    check("R4 R3 cpu_irq_req", cpu_irq_req, (l > p) ? 1 : 0);
                    check("R3 R11 wake_cpu", wake_cpu, (l > 0) ? 1 : 0);
                    do_ack();
                    check("R2 vector", got_vec, (l > p) ? ivec(i) : {base, 8'h10});
                    check("R10 take_lvl", got_lvl, (l > p) ? l : 0);
                end
                irq_req = '0;
            end
            wcfg(i, 0, 0);
        end
        cpu_ipl = 0;

        // R4 i_mask blocks the CPU; R11 wake also drops
        wcfg(3, 5, 0);
        irq_req = 8'h08; i_mask = 1;
        settle();
        check("R4 i_mask req", cpu_irq_req, 0);
        check("R11 i_mask wake", wake_cpu, 0);
        i_mask = 0;
        irq_req = 0;
        wcfg(3, 0, 0);

        // R5 pairwise arbitration
        for (int i = 0; i < N - 1; i++) begin
            for (int j = i + 1; j < N; j++) begin
                for (int li = 1; li <= 3; li++) begin
                    for (int lj = 1; lj <= 3; lj++) begin
                        wcfg(i, li, 0); wcfg(j, lj, 0);
                        irq_req = '0; irq_req[i] = 1; irq_req[j] = 1;
                        settle();
                        do_ack();
                        check("R5 winner", got_vec, (lj > li) ? ivec(j) : ivec(i));
                        check("R5 level", got_lvl, (lj > li) ? lj : li);
                    end
                end
                irq_req = '0;
                wcfg(i, 0, 0); wcfg(j, 0, 0);
            end
        end

        // R6 R12 coprocessor routing, independent of CPU masks
        i_mask = 1; cpu_ipl = 7;
        for (int i = 1; i < N; i++) begin
            wcfg(i, 3, 1);
            irq_req = '0; irq_req[i] = 1;
            settle();
            check("R6 cop_valid", cop_valid, 1);
            check("R6 cop_vec", cop_vec, ivec(i));
            check("R6 cop_lvl", cop_lvl, 3);
            check("R12 wake_cop", wake_cop, 1);
            check("R6 cpu blind", cpu_irq_req, 0);
            irq_req = '0;
            wcfg(i, 0, 1);
            irq_req[i] = 1;
            settle();
            check("R3 cop lvl0", cop_valid, 0);
            check("R3 cop lvl0 wake", wake_cop, 0);
            irq_req = '0;
            wcfg(i, 0, 0);
        end
        i_mask = 0; cpu_ipl = 0;

        // R7 route write to index 0 ignored
        wcfg(0, 4, 1);
        irq_req = 8'h01;
        settle();
        check("R7 cop_valid", cop_valid, 0);
        check("R7 cpu req", cpu_irq_req, 1);
        do_ack();
        check("R7 cpu vec", got_vec, ivec(0));
        irq_req = 0;
        wcfg(0, 0, 0);

        // R8 every combination of special events and one maskable request
        wcfg(1, 4, 0);
        for (int m = 0; m < 256; m++) begin
            logic [7:0] e;
            e = 8'(m);
            trap_req = e[0]; swi_req = e[1]; xirq = e[2]; irq_req = {7'd0, e[3]} << 1;
            acc_viol = {e[4], e[5], e[6]}; sys_call = e[7];
            settle();
            check("R8 req", cpu_irq_req, (m != 0) ? 1 : 0);
            check("R11 wake special", wake_cpu, (m != 0) ? 1 : 0);
            do_ack();
            if (e[0])      check("R8 trap", got_vec, {base, 8'hF8});
            else if (e[1]) check("R8 swi", got_vec, {base, 8'hF6});
            else if (e[2]) check("R8 xirq", got_vec, {base, 8'hF4});
            else if (e[3]) check("R8 maskable", got_vec, ivec(1));
            else if (e[4]) check("R8 acc2", got_vec, {base, 8'h18});
            else if (e[5]) check("R8 acc1", got_vec, {base, 8'h16});
            else if (e[6]) check("R8 acc0", got_vec, {base, 8'h14});
            else if (e[7]) check("R8 sys", got_vec, {base, 8'h12});
            else           check("R9 none", got_vec, {base, 8'h10});
        end
        trap_req = 0; swi_req = 0; xirq = 0; irq_req = 0; acc_viol = 0; sys_call = 0;

        // R11 R8 masked XIRQ still wakes but is not vectored
        xirq = 1; x_mask = 1;
        settle();
        check("R11 xirq masked wake", wake_cpu, 1);
        check("R8 xirq masked req", cpu_irq_req, 0);
        xirq = 0; x_mask = 0;

        // R10 hold across a second acknowledge
        wcfg(5, 2, 0);
        irq_req = 8'h20;
        settle();
        @(negedge clk); cpu_ack = 1;
        @(negedge clk); cpu_ack = 0;
        check("R10 first capture", cpu_vec, ivec(5));
        irq_req = 8'h22; cpu_ack = 1;
        @(negedge clk); cpu_ack = 0;
        @(negedge clk);
        check("R10 held vec", cpu_vec, ivec(5));
        check("R10 held valid", cpu_vec_valid, 1);
        cpu_fetch_done = 1;
        @(negedge clk); cpu_fetch_done = 0;
        check("R10 released", cpu_vec_valid, 0);
        do_ack();
        check("R10 next capture", got_vec, ivec(1));
        irq_req = 0;

        // R13 base write and out-of-range index handled
        @(negedge clk); base_we = 1; base_wdata = 8'h3C;
        @(negedge clk); base_we = 0; base = 8'h3C;
        irq_req = 8'h20;
        settle();
        do_ack();
        check("R13 base vec", got_vec, 16'h3CE8);
        irq_req = 0;
        do_ack();
        check("R13 R9 base spurious", got_vec, 16'h3C10);

        done = 1;
        summary();
        $finish;
    end
endmodule